// File: doc/BRIEF.md
# Single and Double Tap Detector

This block watches a stream of signed acceleration samples, one value per axis, and reports taps. A tap is a short excursion: one or more enabled axes rise to or past a programmable magnitude threshold and then fall back within a programmable maximum time. The first qualified tap produces a one-cycle single-tap pulse. It also latches which axes started the excursion. If double-tap detection is active, the block then waits a programmable quiet (latency) period. After that it opens a programmable window. A second tap that begins inside that window, and also qualifies on duration, produces a one-cycle double-tap pulse.

Time is measured in ticks of an external timebase strobe (`tick`, nominally one pulse per 625 µs). The duration setting counts ticks one for one. The latency and window settings count `SLOW_MULT` ticks per unit. Samples arrive on `smp_valid`, with axis i in bits `[16*i +: 16]` of `smp_data`.

The controller is a state machine with six states:
- IDLE: waiting for a sample over threshold.
- FIRST: measuring the first excursion.
- REJECT: an excursion ran too long; waiting for it to end.
- LATENCY: the quiet period after a single tap.
- WINDOW: waiting for the second tap to begin.
- SECOND: measuring the second excursion.

Transitions are named as follows:
- start: IDLE to FIRST.
- qualify: FIRST to LATENCY, or FIRST to IDLE when double tap is off.
- overrun: FIRST or SECOND to REJECT.
- release: REJECT to IDLE.
- open: LATENCY to WINDOW.
- suppress: LATENCY to IDLE.
- restart: WINDOW to SECOND.
- close: WINDOW to IDLE.
- confirm: SECOND to IDLE.
- mask-reset: any state to IDLE.

Top module: `tap_detector`

## Requirements
- R1: An axis is over threshold when its enable bit in `axis_en` is 1 and its magnitude is at or above `cfg_thresh`. The magnitude is computed as follows: take the absolute value of the 16-bit two's complement sample, shift it right by 4, and saturate it to 255. So -32768 reaches a threshold of 255, while 4079 does not. A sample is "high" when any axis is over threshold and "low" otherwise; only cycles with `smp_valid` = 1 carry samples.
- R2: From IDLE, a high sample starts a tap. The tap qualifies if a low sample arrives before the (`cfg_dur`+1)-th tick counted in FIRST, or in the same cycle as that tick. `single_tap` is then 1 for exactly the one cycle after that low sample.
- R3: If the (`cfg_dur`+1)-th tick arrives with no low sample, the excursion is rejected. It gives no pulse, and the block returns to IDLE only on the next low sample.
- R4: With `cfg_dur` = 0, no tap is ever started, so neither pulse occurs.
- R5: After a single tap, LATENCY counts `cfg_latent`×2 ticks, ignoring samples. When it expires, the newest sample is checked; a sample in the expiry cycle itself counts as the newest. If that sample is high, the block returns to IDLE and that sequence reports no double tap.
- R6: WINDOW lasts `cfg_window`×2 ticks. A high sample in it starts the second tap, including a high sample in the same cycle as the last tick. If the second tap qualifies as in R2, `double_tap` is 1 for one cycle and `single_tap` stays 0. The two pulses are never 1 together.
- R7: With `cfg_latent` = 0 or `cfg_window` = 0, a qualified tap returns straight to IDLE. Every tap is then reported as a single tap and `double_tap` never pulses.
- R8: `tap_src` bit i (bit 0 = axis 0) takes the over-threshold axes of the sample that started the tap. It is updated only in the cycle `single_tap` rises and holds otherwise.
- R9: Any change of `axis_en` returns the block to IDLE and clears its timer in that cycle. `tap_src` is kept.
- R10: After reset, `single_tap`, `double_tap` and `tap_src` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 48 | Three signed 16-bit samples, axis 0 in the low bits |
| axis_en | input | 3 | Per-axis tap enable |
| tick | input | 1 | Timebase strobe |
| cfg_thresh | input | 8 | Magnitude threshold |
| cfg_dur | input | 8 | Maximum excursion length in ticks |
| cfg_latent | input | 8 | Quiet period, 2 ticks per unit |
| cfg_window | input | 8 | Second-tap window, 2 ticks per unit |
| single_tap | output | 1 | One-cycle single-tap event |
| double_tap | output | 1 | One-cycle double-tap event |
| tap_src | output | 3 | Axes that started the last single tap |

## Verification
Two pairs of events can land in the same cycle, and both are judged by priority. In FIRST, a duration tick can coincide with the low sample that ends the excursion. In WINDOW, the closing tick can coincide with the high sample that starts the second tap. The bench provokes both by driving samples and ticks independently at random: ticks arrive in about one cycle in four, samples in three cycles in four, and bursts have random lengths. A cycle-level reference model, written from the requirements, predicts both pulses and `tap_src` for every cycle. In those coincident cycles the model gives the low sample priority over the overrun tick, and the high sample priority over the close tick.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_REJECT,
        ST_LATENCY,
        ST_WINDOW,
        ST_SECOND
    } tap_state_e;

endpackage

// File: rtl/tap_axis_mag.sv
`timescale 1ns/1ps
module tap_axis_mag #(
    parameter int SAMPLE_W  = 16,
    parameter int CFG_W     = 8,
    parameter int MAG_SHIFT = 4
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [CFG_W-1:0]    thresh,
    output logic                above
);
    localparam int ABS_W = SAMPLE_W + 1;

    logic [ABS_W-1:0] ext;
    logic [ABS_W-1:0] abs_v;
    logic [ABS_W-1:0] scaled;
    logic [CFG_W-1:0] mag;

    always_comb begin
        ext    = {sample[SAMPLE_W-1], sample};
        abs_v  = ext[ABS_W-1] ? (~ext + 1'b1) : ext;
        scaled = abs_v >> MAG_SHIFT;
        if (|scaled[ABS_W-1:CFG_W]) begin
            mag = '1;
        end else begin
            mag = scaled[CFG_W-1:0];
        end
        above = (mag >= thresh);
    end

endmodule

// File: rtl/tap_tick_timer.sv
`timescale 1ns/1ps
module tap_tick_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + 1'b1;
    assign expire  = tick && (cnt_inc == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_inc;
        end
    end

endmodule

// File: rtl/tap_limit_sel.sv
`timescale 1ns/1ps
module tap_limit_sel
    import tap_pkg::*;
#(
    parameter int CFG_W     = 8,
    parameter int SLOW_MULT = 2,
    parameter int CNT_W     = 10
) (
    input  tap_state_e       state,
    input  logic [CFG_W-1:0] cfg_dur,
    input  logic [CFG_W-1:0] cfg_latent,
    input  logic [CFG_W-1:0] cfg_window,
    output logic [CNT_W-1:0] limit,
    output logic             tap_on,
    output logic             dbl_on
);
    logic [CNT_W-1:0] dur_lim;
    logic [CNT_W-1:0] lat_lim;
    logic [CNT_W-1:0] win_lim;

    assign dur_lim = CNT_W'(cfg_dur) + 1'b1;
    assign lat_lim = CNT_W'(cfg_latent) * CNT_W'(SLOW_MULT);
    assign win_lim = CNT_W'(cfg_window) * CNT_W'(SLOW_MULT);
    assign tap_on  = (cfg_dur != '0);
    assign dbl_on  = (cfg_latent != '0) && (cfg_window != '0);

    always_comb begin
        unique case (state)
            ST_FIRST, ST_SECOND: limit = dur_lim;
            ST_LATENCY:          limit = lat_lim;
            ST_WINDOW:           limit = win_lim;
            default:             limit = '0;
        endcase
    end

endmodule

// File: rtl/tap_detector.sv
`timescale 1ns/1ps
module tap_detector
    import tap_pkg::*;
#(
    parameter int NUM_AXES  = 3,
    parameter int SAMPLE_W  = 16,
    parameter int CFG_W     = 8,
    parameter int MAG_SHIFT = 4,
    parameter int SLOW_MULT = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         smp_valid,
    input  logic [NUM_AXES*SAMPLE_W-1:0] smp_data,
    input  logic [NUM_AXES-1:0]          axis_en,
    input  logic                         tick,
    input  logic [CFG_W-1:0]             cfg_thresh,
    input  logic [CFG_W-1:0]             cfg_dur,
    input  logic [CFG_W-1:0]             cfg_latent,
    input  logic [CFG_W-1:0]             cfg_window,
    output logic                         single_tap,
    output logic                         double_tap,
    output logic [NUM_AXES-1:0]          tap_src
);
    localparam int CNT_W = CFG_W + $clog2(SLOW_MULT) + 1;

    tap_state_e state_q, state_d;

    logic [NUM_AXES-1:0] hit_raw;
    logic [NUM_AXES-1:0] hit_vec;
    logic                any_hit;
    logic                smp_high;
    logic                smp_low;
    logic                hold_q;
    logic                above_now;
    logic [NUM_AXES-1:0] en_q;
    logic                en_changed;
    logic [NUM_AXES-1:0] cand_q;
    logic                cand_load;
    logic                fire_single;
    logic                fire_double;
    logic [CNT_W-1:0]    limit;
    logic                tap_on;
    logic                dbl_on;
    logic                expire;
    logic                tmr_clr;

    // Per-axis magnitude compare
    for (genvar g = 0; g < NUM_AXES; g++) begin : g_axis
        tap_axis_mag #(
            .SAMPLE_W  (SAMPLE_W),
            .CFG_W     (CFG_W),
            .MAG_SHIFT (MAG_SHIFT)
        ) u_mag (
            .sample (smp_data[g*SAMPLE_W +: SAMPLE_W]),
            .thresh (cfg_thresh),
            .above  (hit_raw[g])
        );
    end

    assign hit_vec    = hit_raw & axis_en;
    assign any_hit    = |hit_vec;
    assign smp_high   = smp_valid && any_hit;
    assign smp_low    = smp_valid && !any_hit;
    assign above_now  = smp_valid ? any_hit : hold_q;
    assign en_changed = (axis_en != en_q);

    tap_limit_sel #(
        .CFG_W     (CFG_W),
        .SLOW_MULT (SLOW_MULT),
        .CNT_W     (CNT_W)
    ) u_lim (
        .state      (state_q),
        .cfg_dur    (cfg_dur),
        .cfg_latent (cfg_latent),
        .cfg_window (cfg_window),
        .limit      (limit),
        .tap_on     (tap_on),
        .dbl_on     (dbl_on)
    );

    assign tmr_clr = (state_d != state_q) || (state_q == ST_IDLE) ||
                     (state_q == ST_REJECT);

    tap_tick_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .tick   (tick),
        .limit  (limit),
        .expire (expire)
    );

    // Next-state logic
    always_comb begin
        state_d     = state_q;
        fire_single = 1'b0;
        fire_double = 1'b0;
        cand_load   = 1'b0;
        if (en_changed) begin
            state_d = ST_IDLE;                       // mask-reset
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (smp_high && tap_on) begin
                        state_d   = ST_FIRST;        // start
                        cand_load = 1'b1;
                    end
                end
                ST_FIRST: begin
                    if (smp_low) begin
                        fire_single = 1'b1;          // qualify
                        state_d     = dbl_on ? ST_LATENCY : ST_IDLE;
                    end else if (expire) begin
                        state_d = ST_REJECT;         // overrun
                    end
                end
                ST_REJECT: begin
                    if (smp_low) begin
                        state_d = ST_IDLE;           // release
                    end
                end
                ST_LATENCY: begin
                    if (expire) begin
                        state_d = above_now ? ST_IDLE : ST_WINDOW; // suppress / open
                    end
                end
                ST_WINDOW: begin
                    if (smp_high) begin
                        state_d = ST_SECOND;         // restart
                    end else if (expire) begin
                        state_d = ST_IDLE;           // close
                    end
                end
                ST_SECOND: begin
                    if (smp_low) begin
                        fire_double = 1'b1;          // confirm
                        state_d     = ST_IDLE;
                    end else if (expire) begin
                        state_d = ST_REJECT;         // overrun
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Bookkeeping of sample history and enable mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            en_q   <= '0;
            cand_q <= '0;
        end else begin
            en_q <= axis_en;
            if (smp_valid) begin
                hold_q <= any_hit;
            end
            if (cand_load) begin
                cand_q <= hit_vec;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            single_tap <= 1'b0;
            double_tap <= 1'b0;
            tap_src    <= '0;
        end else begin
            single_tap <= fire_single;
            double_tap <= fire_double;
            if (fire_single) begin
                tap_src <= cand_q;
            end
        end
    end

endmodule

// File: rtl/tap_detector_chk.sv
`timescale 1ns/1ps
module tap_detector_chk
    import tap_pkg::*;
#(
    parameter int NUM_AXES = 3,
    parameter int CFG_W    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_AXES-1:0] axis_en,
    input logic [CFG_W-1:0]    cfg_dur,
    input logic [CFG_W-1:0]    cfg_latent,
    input logic [CFG_W-1:0]    cfg_window,
    input tap_state_e          state,
    input logic                single_tap,
    input logic                double_tap,
    input logic [NUM_AXES-1:0] tap_src
);

    AST_SINGLE_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        single_tap |-> $past(state) == ST_FIRST); // R2

    AST_SINGLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        single_tap |=> !single_tap); // R2

    AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_REJECT |=> !single_tap && !double_tap); // R3

    AST_DUR_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cfg_dur == '0) |=> state == ST_IDLE); // R4

    AST_DOUBLE_AFTER_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        double_tap |-> $past(state) == ST_SECOND); // R6

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(single_tap && double_tap)); // R6

    AST_NO_LATENCY_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIRST && (cfg_latent == '0 || cfg_window == '0)) |=> state != ST_LATENCY); // R7

    AST_SRC_ONLY_ON_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tap_src) |-> single_tap); // R8

    AST_EN_CHANGE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (axis_en != $past(axis_en)) |=> state == ST_IDLE); // R9

endmodule

bind tap_detector tap_detector_chk #(
    .NUM_AXES (NUM_AXES),
    .CFG_W    (CFG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .axis_en    (axis_en),
    .cfg_dur    (cfg_dur),
    .cfg_latent (cfg_latent),
    .cfg_window (cfg_window),
    .state      (state_q),
    .single_tap (single_tap),
    .double_tap (double_tap),
    .tap_src    (tap_src)
);

// File: tb/tap_detector_tb.sv
`timescale 1ns/1ps
module tap_detector_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [47:0] smp_data = '0;
    logic [2:0]  axis_en = 3'b111;
    logic        tick = 1'b0;
    logic [7:0]  cfg_thresh = 8'd16;
    logic [7:0]  cfg_dur = 8'd3;
    logic [7:0]  cfg_latent = 8'd1;
    logic [7:0]  cfg_window = 8'd2;
    logic        single_tap;
    logic        double_tap;
    logic [2:0]  tap_src;

    int checks = 0;
    int errors = 0;
    int cyc_n = 0;
    int n_single = 0;
    int n_double = 0;
    bit done = 0;

    // Reference model state: 0 idle,1 first,2 reject,3 latency,4 window,5 second
    int       m_st = 0;
    int       m_cnt = 0;
    bit       m_hold = 0;
    bit [2:0] m_en = 3'b000;
    bit [2:0] m_cand = 3'b000;
    bit [2:0] m_src = 3'b000;
    bit       e_single = 0;
    bit       e_double = 0;

    always #2 clk = ~clk;

    tap_detector u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .axis_en    (axis_en),
        .tick       (tick),
        .cfg_thresh (cfg_thresh),
        .cfg_dur    (cfg_dur),
        .cfg_latent (cfg_latent),
        .cfg_window (cfg_window),
        .single_tap (single_tap),
        .double_tap (double_tap),
        .tap_src    (tap_src)
    );

    function automatic bit [2:0] ref_hits(input logic [47:0] d, input logic [2:0] en,
                                          input logic [7:0] thr);
        bit [2:0] h = '0;
        for (int i = 0; i < 3; i++) begin
            int sv = int'($signed(d[i*16 +: 16]));
            int a  = (sv < 0) ? -sv : sv;
            int m  = a >> 4;
            if (m > 255) m = 255;
            h[i] = en[i] && (m >= int'(thr));
        end
        return h;
    endfunction

    task automatic model_step();
        bit [2:0] hv = ref_hits(smp_data, axis_en, cfg_thresh);
        bit any = |hv;
        bit hi = smp_valid && any;
        bit lo = smp_valid && !any;
        int dlim = int'(cfg_dur) + 1;
        int llim = 2 * int'(cfg_latent);
        int wlim = 2 * int'(cfg_window);
        int ns = m_st;
        e_single = 0;
        e_double = 0;
        if (axis_en != m_en) begin
            ns = 0;
        end else begin
            case (m_st)
                0: if (hi && cfg_dur != 0) begin ns = 1; m_cand = hv; end
                1: begin
                    if (lo) begin
                        e_single = 1;
                        m_src = m_cand;
                        ns = (cfg_latent != 0 && cfg_window != 0) ? 3 : 0;
                    end else if (tick && m_cnt + 1 == dlim) ns = 2;
                end
                2: if (lo) ns = 0;
                3: if (tick && m_cnt + 1 == llim) ns = ((smp_valid ? any : m_hold)) ? 0 : 4;
                4: begin
                    if (hi) ns = 5;
                    else if (tick && m_cnt + 1 == wlim) ns = 0;
                end
                5: begin
                    if (lo) begin e_double = 1; ns = 0; end
                    else if (tick && m_cnt + 1 == dlim) ns = 2;
                end
                default: ns = 0;
            endcase
        end
        if (ns != m_st || m_st == 0 || m_st == 2) m_cnt = 0;
        else if (tick) m_cnt = m_cnt + 1;
        if (smp_valid) m_hold = any;
        m_en = axis_en;
        m_st = ns;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc_n);
        end
    endtask

    // One clock: drive inputs, advance model, compare after the edge
    task automatic cyc(input bit v, input logic [47:0] d, input bit t);
        smp_valid = v;
        smp_data  = d;
        tick      = t;
        model_step();
        @(posedge clk);
        #1;
        cyc_n++;
        if (single_tap) n_single++;
        if (double_tap) n_double++;
        chk(single_tap == e_single, "R2 single_tap", int'(single_tap), int'(e_single));
        chk(double_tap == e_double, "R6 double_tap", int'(double_tap), int'(e_double));
        chk(tap_src == m_src, "R8 tap_src", int'(tap_src), int'(m_src));
    endtask

    task automatic drive(input int n, input logic [47:0] d);
        for (int i = 0; i < n; i++) cyc(1'b1, d, (cyc_n % 4) == 0);
    endtask

    localparam logic [47:0] X_HIT = {16'd0, 16'd0, 16'd1000};
    localparam logic [47:0] Y_HIT = {16'd0, 16'd1000, 16'd0};
    localparam logic [47:0] QUIET = 48'd0;

    initial begin
        int s0;
        int d0;
        bit [2:0] src0;
        int burst_left = 0;
        bit [2:0] burst_axes = 0;
        void'($urandom(32'h1bad5eed));
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        chk(single_tap == 1'b0, "R10 single", int'(single_tap), 0);
        chk(double_tap == 1'b0, "R10 double", int'(double_tap), 0);
        chk(tap_src == 3'b000, "R10 src", int'(tap_src), 0);
        rst_n = 1'b1;
        drive(10, QUIET);

        // R2 / R8: single tap on axis 0
        s0 = n_single; d0 = n_double;
        drive(3, X_HIT); drive(60, QUIET);
        chk(n_single - s0 == 1, "R2 single count", n_single - s0, 1);
        chk(n_double - d0 == 0, "R2 no double", n_double - d0, 0);
        chk(tap_src == 3'b001, "R8 src axis0", int'(tap_src), 1);

        // R3: excursion too long
        s0 = n_single;
        drive(24, X_HIT); drive(40, QUIET);
        chk(n_single - s0 == 0, "R3 overrun silent", n_single - s0, 0);

        // R6: double tap on axis 1
        s0 = n_single; d0 = n_double;
        drive(3, Y_HIT); drive(13, QUIET); drive(3, Y_HIT); drive(40, QUIET);
        chk(n_single - s0 == 1, "R6 first single", n_single - s0, 1);
        chk(n_double - d0 == 1, "R6 double count", n_double - d0, 1);
        chk(tap_src == 3'b010, "R8 src axis1", int'(tap_src), 2);

        // R5: still high at latency expiry
        s0 = n_single; d0 = n_double;
        drive(3, X_HIT); drive(1, QUIET); drive(30, X_HIT); drive(40, QUIET);
        chk(n_single - s0 == 1, "R5 single", n_single - s0, 1);
        chk(n_double - d0 == 0, "R5 suppressed", n_double - d0, 0);

        // R7: latency zero
        cfg_latent = 8'd0;
        s0 = n_single; d0 = n_double;
        drive(3, Y_HIT); drive(13, QUIET); drive(3, Y_HIT); drive(40, QUIET);
        chk(n_single - s0 == 2, "R7 two singles", n_single - s0, 2);
        chk(n_double - d0 == 0, "R7 no double", n_double - d0, 0);
        cfg_latent = 8'd1;

        // R4: duration zero
        cfg_dur = 8'd0;
        s0 = n_single;
        drive(3, X_HIT); drive(40, QUIET);
        chk(n_single - s0 == 0, "R4 disabled", n_single - s0, 0);
        cfg_dur = 8'd3;

        // R1: saturation and threshold edge
        cfg_thresh = 8'd255;
        s0 = n_single;
        drive(2, {16'h8000, 16'd0, 16'd0}); drive(40, QUIET);
        chk(n_single - s0 == 1, "R1 saturated hit", n_single - s0, 1);
        chk(tap_src == 3'b100, "R8 src axis2", int'(tap_src), 4);
        s0 = n_single;
        drive(2, {16'd0, 16'd0, 16'd4079}); drive(40, QUIET);
        chk(n_single - s0 == 0, "R1 below edge", n_single - s0, 0);
        cfg_thresh = 8'd16;
        axis_en = 3'b101;
        s0 = n_single;
        drive(3, Y_HIT); drive(40, QUIET);
        chk(n_single - s0 == 0, "R1 masked axis", n_single - s0, 0);

        // R9: mask change mid-tap
        axis_en = 3'b111;
        drive(10, QUIET);
        s0 = n_single; src0 = tap_src;
        drive(2, X_HIT);
        axis_en = 3'b011;
        drive(40, QUIET);
        chk(n_single - s0 == 0, "R9 aborted", n_single - s0, 0);
        chk(tap_src == src0, "R9 src kept", int'(tap_src), int'(src0));

        // Random phase
        for (int blk = 0; blk < 8; blk++) begin
            logic [2:0] ne = 3'($urandom % 8);
            if (ne == axis_en) ne = axis_en ^ 3'b001;
            axis_en    = ne;
            cfg_thresh = 8'(8 + $urandom % 33);
            cfg_dur    = 8'(($urandom % 8 == 0) ? 0 : 1 + $urandom % 5);
            cfg_latent = 8'($urandom % 4);
            cfg_window = 8'($urandom % 5);
            for (int c = 0; c < 600; c++) begin
                logic [47:0] d = '0;
                if (burst_left == 0 && $urandom % 10 == 0) begin
                    burst_left = 1 + $urandom % 14;
                    burst_axes = 3'(1 + $urandom % 7);
                end
                for (int a = 0; a < 3; a++) begin
                    int mag;
                    if (burst_left > 0 && burst_axes[a])
                        mag = int'(cfg_thresh) * 16 + int'($urandom % 2000);
                    else
                        mag = int'($urandom % (int'(cfg_thresh) * 16));
                    if (mag > 32767) mag = 32767;
                    d[a*16 +: 16] = ($urandom % 2 == 0) ? 16'(mag) : 16'(-mag);
                end
                if (burst_left > 0) burst_left--;
                cyc(($urandom % 4) != 0, d, ($urandom % 4) == 0);
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc_n, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule